// File: doc/BRIEF.md
# Flash Write-Cycle Qualifier with Hardware Reset

This block watches the asynchronous control pins of a NOR-style flash memory: chip enable, write enable, output enable and the hardware reset pin. A fast internal clock samples them. Each control pin passes through a two-flop synchronizer and a stability filter, so a low pulse narrower than `FILT_CYC` samples never reaches the qualifier. A write is accepted only when the filtered chip enable and write enable are both low and the filtered output enable is high. The block then issues a one-cycle command strobe on the sample where filtered write enable rises. The strobe carries the address and data that were on the bus at that edge. Command decoding and the flash algorithms downstream consume this strobe.

When power is applied, a write inhibit is armed. It is released only after write enable has been seen high. A rising write-enable edge that was set up during power-up is therefore never taken as a command. The hardware reset pin is qualified by width. Only a filtered low level lasting `RST_MIN` samples produces a one-cycle reset event. That event aborts the operation in progress, clears the configuration and returns the command state machine to read mode. While the reset is held, the block also holds the memory outputs in high impedance and blocks writes. A shorter low pulse leaves no trace. A read-mode request is also raised in the first cycle after power-on reset.

The command output is a plain strobe with no back-pressure. The flash pins cannot be stalled, so a consumer must take every strobe in the cycle it appears.

Top module: `flash_wr_gate`

## Requirements
- R1: Each control pin is synchronized through two flops. Its filtered value takes a new level only after the synchronized pin has held that level for `FILT_CYC` consecutive samples. A write-enable low pulse of fewer than `FILT_CYC` samples produces no strobe, and one of exactly `FILT_CYC` samples does produce one.
- R2: `cmd_valid` is high for the cycle after the sample where filtered write enable goes from 0 to 1, provided that in the preceding sample filtered chip enable and write enable were 0, filtered output enable was 1, and no reset was active.
- R3: Filtered output enable low, or filtered chip enable high, in the sample before the write-enable rise suppresses the strobe.
- R4: After `por_n` is released, writes stay inhibited until filtered write enable has been observed as 1. The first write-enable rise after power-up is never accepted, and once released the inhibit does not return.
- R5: `read_mode_req` is 1 while `por_n` is low and in the first cycle after its release, and otherwise 1 exactly when `reset_evt` is 1.
- R6: When filtered reset stays at 0 for `RST_MIN` consecutive samples, `out_hiz` goes to 1 and `reset_evt` pulses for one cycle (operation abort and configuration clear). `out_hiz` returns to 0 one sample after filtered reset is 1 again.
- R7: No strobe is produced while `out_hiz` is 1, nor in the cycle after it falls.
- R8: A filtered reset low period shorter than `RST_MIN` samples changes neither `out_hiz` nor `reset_evt`.
- R9: `cmd_addr` and `cmd_data` reset to 0 and are updated only together with `cmd_valid`. They then hold the bus values present just before write enable rose, which are delayed `FILT_CYC+2` samples to match the control path.
- R10: `cmd_valid` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| ce_n_i | input | 1 | Chip enable pin, active low |
| we_n_i | input | 1 | Write enable pin, active low |
| oe_n_i | input | 1 | Output enable pin, active low |
| hw_rst_n_i | input | 1 | Hardware reset pin, active low |
| addr_i | input | AW | Address bus pins |
| data_i | input | DW | Data bus pins |
| cmd_valid | output | 1 | One-cycle qualified write strobe |
| cmd_addr | output | AW | Address captured with the strobe |
| cmd_data | output | DW | Data captured with the strobe |
| out_hiz | output | 1 | Memory outputs forced to high impedance |
| reset_evt | output | 1 | One-cycle abort / configuration clear pulse |
| read_mode_req | output | 1 | Return command state machine to read mode |

## Verification
The qualifier is exercised with clean writes that use different addresses and data, which shows that capture follows the bus and is not stale. Write-enable pulses one sample shorter than the filter and exactly as long as the filter expose an off-by-one in the stability counter. Writes with output enable low or chip enable high separate the qualify terms from the edge detector. A power-up with every strobe pin low, followed by a write-enable rise, separates the power-up latch from the reset gating. Reset pulses just below and well above the minimum width, with a write attempted inside the long one, show the width counter and the command gating apart.

// File: rtl/wq_pkg.sv
package wq_pkg;
  localparam int unsigned NPIN    = 4;
  localparam int unsigned PIN_CE  = 0;
  localparam int unsigned PIN_WE  = 1;
  localparam int unsigned PIN_OE  = 2;
  localparam int unsigned PIN_RST = 3;
  // Power-on value of each filtered pin: write enable starts low so the
  // power-up inhibit needs a genuine high level to release.
  localparam logic [NPIN-1:0] PIN_INIT = 4'b1101;
endpackage

// File: rtl/wq_glitch_filt.sv
module wq_glitch_filt #(
  parameter int unsigned FILT_CYC = 3,
  parameter logic        INIT     = 1'b1
) (
  input  logic clk,
  input  logic por_n,
  input  logic pin_i,
  output logic filt_o
);
  localparam int unsigned CW = (FILT_CYC < 2) ? 1 : $clog2(FILT_CYC);

  logic          meta_q, sync_q, filt_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      meta_q <= INIT;
      sync_q <= INIT;
      filt_q <= INIT;
      cnt_q  <= '0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      if (sync_q == filt_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_CYC - 1)) begin
        filt_q <= sync_q;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign filt_o = filt_q;

  AST_FILT_FOLLOWS_SYNC: assert property (@(posedge clk) disable iff (!por_n)
    !$stable(filt_q) |-> (filt_q == $past(sync_q))); // R1
endmodule

// File: rtl/wq_reset_qual.sv
module wq_reset_qual #(
  parameter int unsigned RST_MIN = 8
) (
  input  logic clk,
  input  logic por_n,
  input  logic f_rst_n_i,
  output logic rst_active_o,
  output logic rst_evt_o
);
  localparam int unsigned CW = $clog2(RST_MIN + 1);

  logic [CW-1:0] cnt_q;
  logic          act_q, evt_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
      evt_q <= 1'b0;
    end else if (f_rst_n_i) begin
      cnt_q <= '0;
      act_q <= 1'b0;
      evt_q <= 1'b0;
    end else if (!act_q) begin
      if (cnt_q == CW'(RST_MIN - 1)) begin
        act_q <= 1'b1;
        evt_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        evt_q <= 1'b0;
      end
    end else begin
      evt_q <= 1'b0;
    end
  end

  assign rst_active_o = act_q;
  assign rst_evt_o    = evt_q;

  AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!por_n)
    evt_q |=> !evt_q); // R6
  AST_ACTIVE_NEEDS_LOW: assert property (@(posedge clk) disable iff (!por_n)
    act_q |-> !$past(f_rst_n_i)); // R8
endmodule

// File: rtl/wq_write_qual.sv
module wq_write_qual #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          f_ce_n_i,
  input  logic          f_we_n_i,
  input  logic          f_oe_n_i,
  input  logic          rst_active_i,
  input  logic [AW-1:0] d_addr_i,
  input  logic [DW-1:0] d_data_i,
  output logic          cmd_valid_o,
  output logic [AW-1:0] cmd_addr_o,
  output logic [DW-1:0] cmd_data_o
);
  logic          we_q, qual_q, pu_inh_q, cmd_q;
  logic [AW-1:0] sh_addr_q, cmd_addr_q;
  logic [DW-1:0] sh_data_q, cmd_data_q;
  logic          qual_d, rise_d;

  assign qual_d = !f_ce_n_i && !f_we_n_i && f_oe_n_i && !pu_inh_q && !rst_active_i;
  assign rise_d = f_we_n_i && !we_q && qual_q && !rst_active_i;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      we_q       <= 1'b0;
      qual_q     <= 1'b0;
      pu_inh_q   <= 1'b1;
      cmd_q      <= 1'b0;
      sh_addr_q  <= '0;
      sh_data_q  <= '0;
      cmd_addr_q <= '0;
      cmd_data_q <= '0;
    end else begin
      we_q   <= f_we_n_i;
      qual_q <= qual_d;
      cmd_q  <= rise_d;
      if (f_we_n_i) pu_inh_q <= 1'b0;
      if (!f_we_n_i) begin
        sh_addr_q <= d_addr_i;
        sh_data_q <= d_data_i;
      end
      if (rise_d) begin
        cmd_addr_q <= sh_addr_q;
        cmd_data_q <= sh_data_q;
      end
    end
  end

  assign cmd_valid_o = cmd_q;
  assign cmd_addr_o  = cmd_addr_q;
  assign cmd_data_o  = cmd_data_q;

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!por_n)
    cmd_q |=> !cmd_q); // R10
  AST_NO_CMD_IN_RESET: assert property (@(posedge clk) disable iff (!por_n)
    $past(rst_active_i) |-> !cmd_q); // R7
  AST_PU_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    !pu_inh_q |=> !pu_inh_q); // R4
  AST_PU_BLOCKS: assert property (@(posedge clk) disable iff (!por_n)
    pu_inh_q |-> !cmd_q); // R4
  AST_CAPTURE_HELD: assert property (@(posedge clk) disable iff (!por_n)
    !cmd_q |-> ($stable(cmd_addr_q) && $stable(cmd_data_q))); // R9
endmodule

// File: rtl/flash_wr_gate.sv
module flash_wr_gate
  import wq_pkg::*;
#(
  parameter int unsigned AW       = 8,
  parameter int unsigned DW       = 16,
  parameter int unsigned FILT_CYC = 3,
  parameter int unsigned RST_MIN  = 8
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          ce_n_i,
  input  logic          we_n_i,
  input  logic          oe_n_i,
  input  logic          hw_rst_n_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          cmd_valid,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_data,
  output logic          out_hiz,
  output logic          reset_evt,
  output logic          read_mode_req
);
  localparam int unsigned DLY = FILT_CYC + 2;
  localparam int unsigned PW  = AW + DW;

  logic [NPIN-1:0] raw, flt;
  logic [PW-1:0]   dly_q [DLY];
  logic            rst_active, rst_evt, boot_q;

  assign raw = {hw_rst_n_i, oe_n_i, we_n_i, ce_n_i};

  for (genvar gi = 0; gi < NPIN; gi++) begin : g_pin
    wq_glitch_filt #(.FILT_CYC(FILT_CYC), .INIT(PIN_INIT[gi])) u_filt (
      .clk   (clk),
      .por_n (por_n),
      .pin_i (raw[gi]),
      .filt_o(flt[gi])
    );
  end

  // Bus delay line matched to synchronizer plus filter latency.
  for (genvar gd = 0; gd < DLY; gd++) begin : g_dly
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)       dly_q[gd] <= '0;
      else if (gd == 0) dly_q[gd] <= {addr_i, data_i};
      else              dly_q[gd] <= dly_q[(gd == 0) ? 0 : gd-1];
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) boot_q <= 1'b1;
    else        boot_q <= 1'b0;
  end

  wq_reset_qual #(.RST_MIN(RST_MIN)) u_rst (
    .clk         (clk),
    .por_n       (por_n),
    .f_rst_n_i   (flt[PIN_RST]),
    .rst_active_o(rst_active),
    .rst_evt_o   (rst_evt)
  );

  wq_write_qual #(.AW(AW), .DW(DW)) u_wr (
    .clk         (clk),
    .por_n       (por_n),
    .f_ce_n_i    (flt[PIN_CE]),
    .f_we_n_i    (flt[PIN_WE]),
    .f_oe_n_i    (flt[PIN_OE]),
    .rst_active_i(rst_active),
    .d_addr_i    (dly_q[DLY-1][PW-1:DW]),
    .d_data_i    (dly_q[DLY-1][DW-1:0]),
    .cmd_valid_o (cmd_valid),
    .cmd_addr_o  (cmd_addr),
    .cmd_data_o  (cmd_data)
  );

  assign out_hiz       = rst_active;
  assign reset_evt     = rst_evt;
  assign read_mode_req = boot_q | rst_evt;

  AST_READ_MODE_ON_RESET: assert property (@(posedge clk) disable iff (!por_n)
    reset_evt |-> read_mode_req); // R5
endmodule

// File: tb/flash_wr_gate_bench.sv
module flash_wr_gate_bench;
  localparam int AW = 8, DW = 16, FILT = 3, RMIN = 8, DLY = FILT + 2;

  logic clk = 1'b0, por_n = 1'b0;
  logic ce_n = 1'b0, we_n = 1'b0, oe_n = 1'b1, rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic cmd_valid, out_hiz, reset_evt, read_mode_req;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_data;

  always #2.5 clk = ~clk;

  flash_wr_gate #(.AW(AW), .DW(DW), .FILT_CYC(FILT), .RST_MIN(RMIN)) u_flash_wr_gate (
    .clk(clk), .por_n(por_n), .ce_n_i(ce_n), .we_n_i(we_n), .oe_n_i(oe_n),
    .hw_rst_n_i(rst_n), .addr_i(addr), .data_i(data), .cmd_valid(cmd_valid),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .out_hiz(out_hiz),
    .reset_evt(reset_evt), .read_mode_req(read_mode_req));

  int nvec = 0, nbad = 0, cyc = 0;
  int n_strobe = 0, n_evt = 0, n_rmr = 0, run = 0, max_run = 0;

  // ---------------- reference model ----------------
  int   m_s1 [4], m_s2 [4], m_f [4], m_c [4];
  int   m_weq, m_qual, m_pu, m_cmd, m_rc, m_act, m_evt, m_boot;
  int   m_dl [DLY];
  int   m_sh, m_cap;
  int   init_v [4] = '{1, 0, 1, 1};

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      for (int i = 0; i < 4; i++) begin
        m_s1[i] = init_v[i]; m_s2[i] = init_v[i]; m_f[i] = init_v[i]; m_c[i] = 0;
      end
      for (int k = 0; k < DLY; k++) m_dl[k] = 0;
      m_weq = 0; m_qual = 0; m_pu = 1; m_cmd = 0; m_rc = 0; m_act = 0; m_evt = 0;
      m_boot = 1; m_sh = 0; m_cap = 0;
    end else begin
      int n_cmd, n_qual, pin [4];
      n_cmd  = (m_f[1] == 1 && m_weq == 0 && m_qual == 1 && m_act == 0) ? 1 : 0;
      n_qual = (m_f[0] == 0 && m_f[1] == 0 && m_f[2] == 1 && m_pu == 0 && m_act == 0) ? 1 : 0;
      if (n_cmd == 1) m_cap = m_sh;
      if (m_f[1] == 0) m_sh = m_dl[DLY-1];
      if (m_f[1] == 1) m_pu = 0;
      m_weq = m_f[1]; m_qual = n_qual; m_cmd = n_cmd;
      if (m_f[3] == 1) begin m_rc = 0; m_act = 0; m_evt = 0; end
      else if (m_act == 0) begin
        if (m_rc == RMIN - 1) begin m_act = 1; m_evt = 1; end
        else begin m_rc++; m_evt = 0; end
      end else m_evt = 0;
      pin = '{int'(ce_n), int'(we_n), int'(oe_n), int'(rst_n)};
      for (int i = 0; i < 4; i++) begin
        if (m_s2[i] == m_f[i]) m_c[i] = 0;
        else if (m_c[i] == FILT - 1) begin m_f[i] = m_s2[i]; m_c[i] = 0; end
        else m_c[i]++;
        m_s2[i] = m_s1[i]; m_s1[i] = pin[i];
      end
      for (int k = DLY - 1; k > 0; k--) m_dl[k] = m_dl[k-1];
      m_dl[0] = {addr, data};
      m_boot = 0;
    end
  end

  task automatic cmp(input string tag, input string nm, input int got, input int exp);
    nvec++;
    if (got != exp) begin
      nbad++;
      $display("FAIL %s %s: got %0h expected %0h at cycle %0d", tag, nm, got, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (por_n) begin
      cmp("R2", "cmd_valid", int'(cmd_valid), m_cmd);
      cmp("R9", "cmd_addr/data", int'({cmd_addr, cmd_data}), m_cap);
      cmp("R6", "out_hiz", int'(out_hiz), m_act);
      cmp("R6", "reset_evt", int'(reset_evt), m_evt);
      cmp("R5", "read_mode_req", int'(read_mode_req), (m_boot | m_evt));
      if (cmd_valid) begin n_strobe++; run++; if (run > max_run) max_run = run; end
      else run = 0;
      if (reset_evt) n_evt++;
      if (read_mode_req) n_rmr++;
    end
    if (cyc == 100000) begin
      nbad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                    input logic ce_v, input logic oe_v, input int low_len);
    addr = a; data = d; ce_n = ce_v; oe_n = oe_v;
    wait_cyc(4); we_n = 1'b0;
    wait_cyc(low_len); we_n = 1'b1;
    wait_cyc(10); ce_n = 1'b1; oe_n = 1'b1;
    wait_cyc(6);
  endtask

  initial begin
    int s0, e0;
    wait_cyc(3);
    cmp("R5", "read_mode_req in reset", int'(read_mode_req), 1);
    cmp("R9", "cmd_data in reset", int'(cmd_data), 0);
    por_n = 1'b1;
    // R4: power-up with write enable, chip enable and reset pin low
    wait_cyc(4); rst_n = 1'b1;
    wait_cyc(20);
    cmp("R8", "short power-up reset hiz", int'(out_hiz), 0);
    cmp("R8", "short power-up reset events", n_evt, 0);
    s0 = n_strobe; we_n = 1'b1; wait_cyc(15);
    cmp("R4", "power-up rise strobes", n_strobe - s0, 0);
    ce_n = 1'b1; wait_cyc(6);
    // R2 / R9: clean writes
    s0 = n_strobe; wr(8'h12, 16'hABCD, 1'b0, 1'b1, 8);
    cmp("R2", "write strobes", n_strobe - s0, 1);
    cmp("R9", "captured data", int'(cmd_data), 16'hABCD);
    s0 = n_strobe; wr(8'h34, 16'h5555, 1'b0, 1'b1, 8);
    cmp("R9", "captured addr", int'(cmd_addr), 8'h34);
    // R1: glitch below and at filter length
    s0 = n_strobe; wr(8'h56, 16'h1111, 1'b0, 1'b1, FILT - 1);
    cmp("R1", "short WE pulse strobes", n_strobe - s0, 0);
    s0 = n_strobe; wr(8'h57, 16'h2222, 1'b0, 1'b1, FILT);
    cmp("R1", "filter-length WE pulse strobes", n_strobe - s0, 1);
    // R3: logical inhibits
    s0 = n_strobe; wr(8'h60, 16'h3333, 1'b0, 1'b0, 8);
    cmp("R3", "OE low strobes", n_strobe - s0, 0);
    s0 = n_strobe; wr(8'h61, 16'h4444, 1'b1, 1'b1, 8);
    cmp("R3", "CE high strobes", n_strobe - s0, 0);
    cmp("R9", "data held after inhibit", int'(cmd_data), 16'h2222);
    // R8: reset pulse below minimum width
    e0 = n_evt; rst_n = 1'b0; wait_cyc(RMIN - 2); rst_n = 1'b1; wait_cyc(20);
    cmp("R8", "short reset events", n_evt - e0, 0);
    // R6 / R7: qualified reset with a write inside it
    e0 = n_evt; s0 = n_rmr; rst_n = 1'b0; wait_cyc(18);
    cmp("R6", "hiz during long reset", int'(out_hiz), 1);
    begin
      int st; st = n_strobe;
      wr(8'h70, 16'h7777, 1'b0, 1'b1, 8);
      cmp("R7", "strobes during reset", n_strobe - st, 0);
    end
    rst_n = 1'b1; wait_cyc(12);
    cmp("R6", "hiz after release", int'(out_hiz), 0);
    cmp("R6", "reset event count", n_evt - e0, 1);
    cmp("R5", "read mode request count", n_rmr - s0, 1);
    s0 = n_strobe; wr(8'h80, 16'h8888, 1'b0, 1'b1, 8);
    cmp("R2", "write after reset strobes", n_strobe - s0, 1);
    cmp("R10", "max strobe width", max_run, 1);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule